// File: doc/BRIEF.md
# Receive FIFO Hysteresis Flow Controller

This block watches the fill level of a serial receiver's FIFO and throttles the far end when the FIFO fills up. It compares the level against a programmable high mark and low mark. When the level reaches the high mark, the block enters a throttled state. It leaves that state only once the level falls strictly below the low mark. The gap between the two marks keeps the control from chattering.

A single throttled bit drives two kinds of flow control. The first is in-band: the block asks the transmitter to send a stop character (XOFF) or a resume character (XON) and holds that request until the transmitter reports that the character has gone out. The second is out-of-band: the active-low RTS and DTR lines are de-asserted while the block is throttled. RTS is governed by its own enable bit and DTR by a 2-bit mode field. A low mark of zero is not a legal setting. While it is programmed, the block freezes its flow-control state and raises no new requests.

Top module: `rxq_flow_throttle`

## Requirements
- R1: During and directly after reset, ctlReq is 0 and rtsN and dtrN are both 0 (lines asserted); the block starts unthrottled.
- R2: When unthrottled with a valid low mark and fifoLevel >= highMark, the block becomes throttled on the next clock edge. If inBandEn is 1, it also raises ctlReq on that edge, with ctlChar = XOFF (default code 0x13).
- R3: When throttled, the block leaves the throttled state only when fifoLevel < lowMark (strictly). A level equal to lowMark keeps it throttled. On release with inBandEn = 1, ctlReq is raised with ctlChar = XON (default code 0x11).
- R4: Each crossing produces exactly one request. After an acknowledged XOFF, a level that stays at or above highMark raises no further request.
- R5: A raised request stays on ctlReq until a cycle with txDone = 1; it drops on the edge that samples txDone. If a new crossing happens in that same cycle, the new request wins.
- R6: If an XON request is still pending when the level reaches highMark again, the request is replaced by XOFF without ctlReq dropping.
- R7: While lowMark = 0, the throttled state does not change and no new request is raised, whatever fifoLevel is. txDone still clears a pending request.
- R8: With rtsAutoEn = 1, rtsN is 1 exactly while throttled. With rtsAutoEn = 0, rtsN is 0.
- R9: With dtrMode = 2'b01, dtrN is 1 exactly while throttled. Every other dtrMode code (00, 10, 11) holds dtrN at 0.
- R10: With inBandEn = 0, crossings still change the throttled state and the RTS/DTR lines, but raise no request.
- R11: A level with lowMark <= fifoLevel < highMark changes nothing: no state change and no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoLevel | input | LEVEL_W | Current receive FIFO fill level |
| highMark | input | THR_W | Throttle threshold |
| lowMark | input | THR_W | Release threshold (zero is invalid) |
| inBandEn | input | 1 | Enable XON/XOFF requests |
| rtsAutoEn | input | 1 | Enable automatic RTS control |
| dtrMode | input | 2 | DTR control mode; 2'b01 selects automatic flow control |
| txDone | input | 1 | Transmitter has sent the requested character |
| ctlReq | output | 1 | Request to send a flow-control character |
| ctlChar | output | 8 | Character to send (XON or XOFF code) |
| rtsN | output | 1 | Active-low RTS level |
| dtrN | output | 1 | Active-low DTR level |

## Verification
The bench targets the threshold boundaries. A level equal to the low mark must not release the throttle, and one below it must; a design that tested less-than-or-equal would send XON one character early. The bench also retriggers the high mark while an XON is still pending. A design that queued XON and XOFF separately, or dropped the request in between, would show a gap in ctlReq or send the wrong character. Finally, the bench sets the low mark to zero while throttled and raises an acknowledge in the same cycle as a crossing. It checks that the frozen state and the new request survive; a design that ignored either rule would release the line or lose the request.

// File: rtl/rxq_flow_pkg.sv
package rxq_flow_pkg;
  // DTR mode code that hands the pin to automatic flow control
  localparam logic [1:0] DTR_AUTO = 2'b01;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic throttled;
    logic reqPend;
    logic sendXoff;
  } flowStrobe_t;
endpackage

// File: rtl/rxq_flow_dp.sv
module rxq_flow_dp
  import rxq_flow_pkg::*;
#(
  parameter int LEVEL_W = 8,
  parameter int THR_W = 8,
  parameter logic [7:0] XON_CODE = 8'h11,
  parameter logic [7:0] XOFF_CODE = 8'h13
) (
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic [THR_W-1:0]   highMark,
  input  logic [THR_W-1:0]   lowMark,
  input  logic               rtsAutoEn,
  input  logic [1:0]         dtrMode,
  input  flowStrobe_t        strobe,
  output logic               atHigh,
  output logic               belowLow,
  output logic               marksValid,
  output logic               ctlReq,
  output logic [7:0]         ctlChar,
  output logic               rtsN,
  output logic               dtrN
);
  localparam int CMP_W = (LEVEL_W > THR_W) ? LEVEL_W : THR_W;

  logic [CMP_W-1:0] levelExt;
  logic [CMP_W-1:0] highExt;
  logic [CMP_W-1:0] lowExt;

  assign levelExt = CMP_W'(fifoLevel);
  assign highExt  = CMP_W'(highMark);
  assign lowExt   = CMP_W'(lowMark);

  always_comb begin
    marksValid = (lowMark != '0);
    atHigh     = (levelExt >= highExt);
    belowLow   = (levelExt < lowExt);
  end

  always_comb begin
    ctlReq  = strobe.reqPend;
    ctlChar = strobe.sendXoff ? XOFF_CODE : XON_CODE;
    rtsN    = rtsAutoEn && strobe.throttled;
    dtrN    = (dtrMode == DTR_AUTO) && strobe.throttled;
  end
endmodule

// File: rtl/rxq_flow_ctl.sv
module rxq_flow_ctl
  import rxq_flow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        atHigh,
  input  logic        belowLow,
  input  logic        marksValid,
  input  logic        inBandEn,
  input  logic        txDone,
  output flowStrobe_t strobe
);
  logic throttled;
  logic reqPend;
  logic sendXoff;
  logic raiseEvt;
  logic releaseEvt;

  always_comb begin
    raiseEvt   = marksValid && atHigh && !throttled;
    releaseEvt = marksValid && belowLow && throttled;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      throttled <= 1'b0;
      reqPend   <= 1'b0;
      sendXoff  <= 1'b0;
    end else begin
      if (raiseEvt) begin
        throttled <= 1'b1;
      end else if (releaseEvt) begin
        throttled <= 1'b0;
      end
      // a fresh crossing overrides both a pending request and an acknowledge
      if ((raiseEvt || releaseEvt) && inBandEn) begin
        reqPend  <= 1'b1;
        sendXoff <= raiseEvt;
      end else if (txDone) begin
        reqPend <= 1'b0;
      end
    end
  end

  assign strobe = '{throttled: throttled, reqPend: reqPend, sendXoff: sendXoff};
endmodule

// File: rtl/rxq_flow_throttle.sv
module rxq_flow_throttle
  import rxq_flow_pkg::*;
#(
  parameter int LEVEL_W = 8,
  parameter int THR_W = 8,
  parameter logic [7:0] XON_CODE = 8'h11,
  parameter logic [7:0] XOFF_CODE = 8'h13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic [THR_W-1:0]   highMark,
  input  logic [THR_W-1:0]   lowMark,
  input  logic               inBandEn,
  input  logic               rtsAutoEn,
  input  logic [1:0]         dtrMode,
  input  logic               txDone,
  output logic               ctlReq,
  output logic [7:0]         ctlChar,
  output logic               rtsN,
  output logic               dtrN
);
  flowStrobe_t strobe;
  logic atHigh;
  logic belowLow;
  logic marksValid;

  rxq_flow_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .atHigh     (atHigh),
    .belowLow   (belowLow),
    .marksValid (marksValid),
    .inBandEn   (inBandEn),
    .txDone     (txDone),
    .strobe     (strobe)
  );

  rxq_flow_dp #(
    .LEVEL_W   (LEVEL_W),
    .THR_W     (THR_W),
    .XON_CODE  (XON_CODE),
    .XOFF_CODE (XOFF_CODE)
  ) u_dp (
    .fifoLevel  (fifoLevel),
    .highMark   (highMark),
    .lowMark    (lowMark),
    .rtsAutoEn  (rtsAutoEn),
    .dtrMode    (dtrMode),
    .strobe     (strobe),
    .atHigh     (atHigh),
    .belowLow   (belowLow),
    .marksValid (marksValid),
    .ctlReq     (ctlReq),
    .ctlChar    (ctlChar),
    .rtsN       (rtsN),
    .dtrN       (dtrN)
  );
endmodule

// File: rtl/rxq_flow_throttle_chk.sv
module rxq_flow_throttle_chk #(
  parameter int LEVEL_W = 8,
  parameter int THR_W = 8,
  parameter logic [7:0] XON_CODE = 8'h11,
  parameter logic [7:0] XOFF_CODE = 8'h13
) (
  input logic               clk,
  input logic               rstN,
  input logic [LEVEL_W-1:0] fifoLevel,
  input logic [THR_W-1:0]   highMark,
  input logic [THR_W-1:0]   lowMark,
  input logic               rtsAutoEn,
  input logic [1:0]         dtrMode,
  input logic               txDone,
  input logic               ctlReq,
  input logic [7:0]         ctlChar,
  input logic               rtsN,
  input logic               dtrN
);
  localparam int CMP_W = (LEVEL_W > THR_W) ? LEVEL_W : THR_W;

  a_r5_hold_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (ctlReq && !txDone) |=> ctlReq);

  a_r5_drop_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctlReq) |-> $past(txDone));

  a_r2_xoff_at_high: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctlReq) && ctlChar == XOFF_CODE) |->
      $past(CMP_W'(fifoLevel) >= CMP_W'(highMark)));

  a_r3_xon_below_low: assert property (@(posedge clk) disable iff (!rstN)
    (ctlReq && ctlChar == XON_CODE && !($past(ctlReq) && $past(ctlChar) == XON_CODE)) |->
      $past(CMP_W'(fifoLevel) < CMP_W'(lowMark)));

  a_r7_no_req_on_zero_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlReq) |-> $past(lowMark != '0));

  a_r7_rts_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lowMark == '0 && rtsAutoEn) && rtsAutoEn) |-> (rtsN == $past(rtsN)));

  a_r8_rts_off_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !rtsAutoEn |-> !rtsN);

  a_r9_dtr_manual_low: assert property (@(posedge clk) disable iff (!rstN)
    (dtrMode != 2'b01) |-> !dtrN);
endmodule

bind rxq_flow_throttle rxq_flow_throttle_chk #(
  .LEVEL_W   (LEVEL_W),
  .THR_W     (THR_W),
  .XON_CODE  (XON_CODE),
  .XOFF_CODE (XOFF_CODE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fifoLevel (fifoLevel),
  .highMark  (highMark),
  .lowMark   (lowMark),
  .rtsAutoEn (rtsAutoEn),
  .dtrMode   (dtrMode),
  .txDone    (txDone),
  .ctlReq    (ctlReq),
  .ctlChar   (ctlChar),
  .rtsN      (rtsN),
  .dtrN      (dtrN)
);

// File: tb/rxq_flow_throttle_bench.sv
`timescale 1ns/1ps
module rxq_flow_throttle_bench;
  localparam logic [7:0] XON = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;

  typedef struct {
    logic       req;
    logic [7:0] chr;
    logic       rts;
    logic       dtr;
    string      tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] fifoLevel = '0;
  logic [7:0] highMark = 8'd100;
  logic [7:0] lowMark = 8'd64;
  logic inBandEn = 1'b1;
  logic rtsAutoEn = 1'b1;
  logic [1:0] dtrMode = 2'b01;
  logic txDone = 1'b0;
  logic ctlReq;
  logic [7:0] ctlChar;
  logic rtsN;
  logic dtrN;

  // next configuration, applied by the driver
  logic [7:0] nHigh = 8'd100;
  logic [7:0] nLow = 8'd64;
  logic nInBand = 1'b1;
  logic nRts = 1'b1;
  logic [1:0] nDtr = 2'b01;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  expItem_t sbq[$];

  always #4 clk = ~clk;

  rxq_flow_throttle u_rxq_flow_throttle (
    .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel), .highMark(highMark),
    .lowMark(lowMark), .inBandEn(inBandEn), .rtsAutoEn(rtsAutoEn),
    .dtrMode(dtrMode), .txDone(txDone), .ctlReq(ctlReq), .ctlChar(ctlChar),
    .rtsN(rtsN), .dtrN(dtrN)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: apply inputs for one cycle, then queue what the ports must show
  task automatic step(input logic [7:0] lvl, input logic ack, input logic eReq,
                      input logic [7:0] eChr, input logic eRts, input logic eDtr,
                      input string tag);
    expItem_t it;
    @(negedge clk);
    #1;
    fifoLevel = lvl; txDone = ack;
    highMark = nHigh; lowMark = nLow; inBandEn = nInBand;
    rtsAutoEn = nRts; dtrMode = nDtr;
    @(posedge clk);
    it.req = eReq; it.chr = eChr; it.rts = eRts; it.dtr = eDtr; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compare at the falling edge after each queued cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        expItem_t it;
        it = sbq.pop_front();
        check(ctlReq === it.req, it.tag, "ctlReq", ctlReq, it.req);
        if (it.req) check(ctlChar === it.chr, it.tag, "ctlChar", ctlChar, it.chr);
        check(rtsN === it.rts, it.tag, "rtsN", rtsN, it.rts);
        check(dtrN === it.dtr, it.tag, "dtrN", dtrN, it.dtr);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ctlReq === 1'b0, "R1", "ctlReq in reset", ctlReq, 0);
    check(rtsN === 1'b0 && dtrN === 1'b0, "R1", "lines in reset", {rtsN, dtrN}, 0);
    rstN = 1'b1;
    step(8'd50, 0, 0, XON, 0, 0, "R1");
    step(8'd99, 0, 0, XON, 0, 0, "R11");
    step(8'd100, 0, 1, XOFF, 1, 1, "R2");
    step(8'd100, 0, 1, XOFF, 1, 1, "R5");
    step(8'd100, 1, 0, XOFF, 1, 1, "R5");
    step(8'd120, 0, 0, XOFF, 1, 1, "R4");
    step(8'd64, 0, 0, XOFF, 1, 1, "R3");
    step(8'd80, 0, 0, XOFF, 1, 1, "R11");
    step(8'd63, 0, 1, XON, 0, 0, "R3");
    step(8'd100, 0, 1, XOFF, 1, 1, "R6");
    step(8'd90, 1, 0, XOFF, 1, 1, "R5");
    step(8'd10, 1, 1, XON, 0, 0, "R5");
    step(8'd10, 1, 0, XON, 0, 0, "R5");
    // zero low mark while unthrottled
    nLow = 8'd0;
    step(8'd200, 0, 0, XON, 0, 0, "R7");
    step(8'd0, 0, 0, XON, 0, 0, "R7");
    nLow = 8'd64;
    step(8'd0, 0, 0, XON, 0, 0, "R11");
    // no in-band requests
    nInBand = 1'b0;
    step(8'd110, 0, 0, XON, 1, 1, "R10");
    step(8'd30, 0, 0, XON, 0, 0, "R10");
    // RTS disabled, DTR mode sweep
    nInBand = 1'b1; nRts = 1'b0;
    step(8'd110, 0, 1, XOFF, 0, 1, "R8");
    nDtr = 2'b10;
    step(8'd110, 1, 0, XOFF, 0, 0, "R9");
    nDtr = 2'b11;
    step(8'd110, 0, 0, XOFF, 0, 0, "R9");
    nDtr = 2'b00;
    step(8'd110, 0, 0, XOFF, 0, 0, "R9");
    nDtr = 2'b01; nRts = 1'b1;
    step(8'd110, 0, 0, XOFF, 1, 1, "R8");
    // zero low mark while throttled: no release
    nLow = 8'd0;
    step(8'd0, 0, 0, XOFF, 1, 1, "R7");
    step(8'd0, 0, 0, XOFF, 1, 1, "R7");
    nLow = 8'd64;
    step(8'd0, 0, 1, XON, 0, 0, "R3");
    step(8'd0, 1, 0, XON, 0, 0, "R5");
    // tight marks: low=1, high=1
    nLow = 8'd1; nHigh = 8'd1;
    step(8'd1, 0, 1, XOFF, 1, 1, "R2");
    step(8'd0, 1, 1, XON, 0, 0, "R3");
    step(8'd0, 1, 0, XON, 0, 0, "R5");
    // top-of-range high mark
    nLow = 8'd200; nHigh = 8'd255;
    step(8'd254, 0, 0, XON, 0, 0, "R11");
    step(8'd255, 0, 1, XOFF, 1, 1, "R2");
    step(8'd255, 1, 0, XOFF, 1, 1, "R4");
    step(8'd200, 0, 0, XOFF, 1, 1, "R3");
    step(8'd199, 0, 1, XON, 0, 0, "R3");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule